// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames: a start bit, seven or eight data bits, an optional parity bit, and one stop bit. The host writes a byte into a single holding register. On the next bit-rate tick with transmission enabled, that byte moves into a shift register and the start bit is driven. The tick is a one-cycle pulse in the system clock domain that marks each bit boundary.

The holding register is freed when its byte moves into the shift register. At that same tick the block raises its empty flag and emits a one-cycle event. An interrupt controller or a DMA engine can use that event to supply the next byte. A byte written while a frame is still shifting starts right after that frame's stop bit, with no idle time between the two frames. Frame length and parity are captured when each frame starts.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset, `hold_empty` is 1, `txd` is 1, `tx_busy` is 0 and `empty_evt` is 0.
- R2: A host write (`wr_valid`=1) sets `hold_empty` to 0 in the following cycle.
- R3: On the first tick after a byte is pending with `tx_en`=1, `txd` goes to 0 (start bit). In that same cycle `hold_empty` goes to 1 and `empty_evt` pulses.
- R4: Data bits follow the start bit least significant bit first, one bit per tick. Eight bits are sent when `len7`=0. Bits 6..0 are sent when `len7`=1, and bit 7 is not sent. `txd` changes only in the cycle after a tick.
- R5: With `par_en`=1, one parity bit follows the last data bit. With `par_odd`=0 it makes the count of ones in the sent data bits plus the parity bit even; with `par_odd`=1 it makes that count odd. With `par_en`=0 no parity bit is sent. The stop bit (1, one tick long) follows directly.
- R6: A byte written while a frame is in progress starts at the tick that ends the current stop bit. Consecutive start bits are exactly one frame length apart in ticks.
- R7: `tx_busy` is 1 from the start-bit cycle to the end of the stop bit. It returns to 0 when no further frame follows.
- R8: While `tx_en`=0 no frame starts and `txd` stays 1. A pending byte is kept (`hold_empty` stays 0) and is sent once `tx_en` returns to 1.
- R9: `empty_evt` is high for exactly one cycle per byte moved into the shift register, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en | input | 1 | 1 adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Host write data |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register empty flag |
| tx_busy | output | 1 | Frame in progress |
| empty_evt | output | 1 | One-cycle pulse when the holding register is freed |

## Verification
A wrong frame state shows on `txd` within one tick: a bit is missing, an extra bit appears, the parity value is wrong, or the stop bit is late. The bench decodes every frame bit by bit against a queue of expected bytes. A wrong holding-register flag shows in the cycle after a write or a load, as a stale `hold_empty`, a missing `empty_evt`, or a frame that starts while disabled. A gap between back-to-back frames shows at the next start bit, as a wrong tick distance from the previous start.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

    // Parity bit that brings the ones count to the requested sense.
    function automatic logic parity_bit(input logic ones_odd, input logic odd_sense);
        return ones_odd ^ odd_sense;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
            evt  <= 1'b0;
        end else begin
            evt <= take;
            if (wr_valid) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> full);

    assert_load_frees_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_valid) |=> !full);

    assert_take_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> full);

    assert_evt_single_R9: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  tx_cfg_t           cfg,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              txd,
    output logic              busy
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

    tx_state_e         st;
    tx_cfg_t           cfg_r;
    logic [DATA_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;
    logic              par_r;
    logic [DATA_W-1:0] mask;
    logic              par_next;
    logic              frame_slot;

    always_comb begin
        mask = '1;
        if (cfg.len7) mask[DATA_W-1] = 1'b0;
        par_next   = parity_bit(^(hold_data & mask), cfg.par_odd);
        frame_slot = (st == ST_IDLE) || (st == ST_STOP);
        take       = tick && tx_en && hold_full && frame_slot;
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            txd   <= 1'b1;
            sreg  <= '0;
            idx   <= '0;
            cfg_r <= '0;
            par_r <= 1'b0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE, ST_STOP: begin
                    if (take) begin
                        st    <= ST_START;
                        txd   <= 1'b0;
                        sreg  <= hold_data;
                        cfg_r <= cfg;
                        par_r <= par_next;
                    end else begin
                        st  <= ST_IDLE;
                        txd <= 1'b1;
                    end
                end
                ST_START: begin
                    st  <= ST_DATA;
                    idx <= '0;
                    txd <= sreg[0];
                end
                ST_DATA: begin
                    if (idx == (cfg_r.len7 ? LAST_SHORT : LAST_FULL)) begin
                        if (cfg_r.par_en) begin
                            st  <= ST_PAR;
                            txd <= par_r;
                        end else begin
                            st  <= ST_STOP;
                            txd <= 1'b1;
                        end
                    end else begin
                        idx  <= idx + 1'b1;
                        sreg <= sreg >> 1;
                        txd  <= sreg[1];
                    end
                end
                ST_PAR: begin
                    st  <= ST_STOP;
                    txd <= 1'b1;
                end
                default: begin
                    st  <= ST_IDLE;
                    txd <= 1'b1;
                end
            endcase
        end
    end

    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> (!txd && busy));

    assert_bit_held_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd));

    assert_parity_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAR) |-> cfg_r.par_en);

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !tx_en) |=> !busy);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       tx_en,
    input  logic       len7,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_busy,
    output logic       empty_evt
);

    localparam int DATA_W = 8;

    logic              take;
    logic              full;
    logic [DATA_W-1:0] hold_data;
    tx_cfg_t           cfg;

    assign cfg        = '{len7: len7, par_en: par_en, par_odd: par_odd};
    assign hold_empty = ~full;

    sertx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (full),
        .data     (hold_data),
        .evt      (empty_evt)
    );

    sertx_shift #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .tx_en     (tx_en),
        .cfg       (cfg),
        .hold_full (full),
        .hold_data (hold_data),
        .take      (take),
        .txd       (txd),
        .busy      (tx_busy)
    );

    assert_evt_with_start_R9: assert property (@(posedge clk) disable iff (rst)
        empty_evt |-> (!txd && hold_empty && tx_busy));

endmodule

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;

    typedef struct {
        logic [7:0] d;
        logic       l7;
        logic       pe;
        logic       po;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       len7 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       hold_empty;
    logic       tx_busy;
    logic       empty_evt;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];
    exp_t cur;
    int   mstate = 0;
    int   bi = 0;
    logic [7:0] rx = 8'h00;
    int   tick_num = 0;
    int   frames = 0;
    logic end_pending = 1'b0;
    logic b2b = 1'b0;
    logic prev_valid = 1'b0;
    int   prev_start = 0;
    int   prev_len = 0;
    int   tcnt = 0;
    logic tick_seen = 1'b0;

    always #2.5 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en),
        .len7(len7), .par_en(par_en), .par_odd(par_odd),
        .wr_valid(wr_valid), .wr_data(wr_data), .txd(txd),
        .hold_empty(hold_empty), .tx_busy(tx_busy), .empty_evt(empty_evt)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // tick every fourth cycle, driven away from the active edge
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        bit_tick = (tcnt == 0);
    end

    always @(posedge clk) tick_seen <= bit_tick;

    // monitor: decodes frames and compares them with the queue
    always @(negedge clk) begin
        if (!rst && tick_seen) begin
            tick_num++;
            case (mstate)
                0: begin
                    if (txd == 1'b0) begin
                        if (q.size() == 0) begin
                            check(1'b0, "R8 unexpected frame", 0, 1);
                        end else begin
                            cur = q.pop_front();
                            check(empty_evt == 1'b1, "R3 empty_evt at start", int'(empty_evt), 1);
                            check(hold_empty == 1'b1, "R3 hold_empty at start", int'(hold_empty), 1);
                            check(tx_busy == 1'b1, "R7 busy at start", int'(tx_busy), 1);
                            if (b2b && prev_valid)
                                check(tick_num - prev_start == prev_len, "R6 start spacing",
                                      tick_num - prev_start, prev_len);
                            prev_valid = 1'b1;
                            prev_start = tick_num;
                            prev_len = 2 + (cur.l7 ? 7 : 8) + (cur.pe ? 1 : 0);
                            mstate = 1;
                            bi = 0;
                            rx = 8'h00;
                            end_pending = 1'b0;
                        end
                    end else if (end_pending) begin
                        check(tx_busy == 1'b0, "R7 busy low after stop", int'(tx_busy), 0);
                        end_pending = 1'b0;
                    end
                end
                1: begin
                    if (bi == 0)
                        check(empty_evt == 1'b0, "R9 evt one cycle", int'(empty_evt), 0);
                    if (!tx_busy) check(1'b0, "R7 busy in data", 0, 1);
                    rx[bi] = txd;
                    bi++;
                    if (bi == (cur.l7 ? 7 : 8)) mstate = cur.pe ? 2 : 3;
                end
                2: begin
                    check(txd == ((^(cur.d & (cur.l7 ? 8'h7F : 8'hFF))) ^ cur.po),
                          "R5 parity bit", int'(txd),
                          int'((^(cur.d & (cur.l7 ? 8'h7F : 8'hFF))) ^ cur.po));
                    mstate = 3;
                end
                default: begin
                    check(txd == 1'b1, "R5 stop bit", int'(txd), 1);
                    check(rx == (cur.d & (cur.l7 ? 8'h7F : 8'hFF)), "R4 data bits",
                          int'(rx), int'(cur.d & (cur.l7 ? 8'h7F : 8'hFF)));
                    frames++;
                    mstate = 0;
                    end_pending = 1'b1;
                end
            endcase
        end
    end

    // driver: writes one byte when the holding register is free
    task automatic send(input logic [7:0] d);
        exp_t e;
        do @(negedge clk); while (!hold_empty);
        wr_valid = 1'b1;
        wr_data = d;
        e.d = d; e.l7 = len7; e.pe = par_en; e.po = par_odd;
        q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
        check(hold_empty == 1'b0, "R2 write clears empty", int'(hold_empty), 0);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || mstate != 0 || tx_busy);
        repeat (8) @(negedge clk);
    endtask

    task automatic set_cfg(input logic l7, input logic pe, input logic po);
        len7 = l7; par_en = pe; par_odd = po;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(hold_empty == 1'b1, "R1 reset empty", int'(hold_empty), 1);
        check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        check(tx_busy == 1'b0, "R1 reset busy", int'(tx_busy), 0);
        check(empty_evt == 1'b0, "R1 reset evt", int'(empty_evt), 0);

        tx_en = 1'b1;
        set_cfg(1'b0, 1'b0, 1'b0);
        send(8'hA5);
        wait_idle();

        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h3C);
        wait_idle();
        send(8'h01);
        wait_idle();

        // back-to-back, R6
        b2b = 1'b1; prev_valid = 1'b0;
        send(8'h5A); send(8'hC3); send(8'h7E);
        wait_idle();
        b2b = 1'b0;

        set_cfg(1'b1, 1'b1, 1'b1);
        send(8'hFF);
        wait_idle();
        send(8'h80);
        wait_idle();
        set_cfg(1'b1, 1'b0, 1'b0);
        b2b = 1'b1; prev_valid = 1'b0;
        send(8'h55); send(8'hAA);
        wait_idle();
        b2b = 1'b0;
        set_cfg(1'b1, 1'b1, 1'b0);
        send(8'h13);
        wait_idle();
        set_cfg(1'b0, 1'b1, 1'b1);
        send(8'hE7);
        wait_idle();
        send(8'h00);
        wait_idle();

        // disabled, R8
        tx_en = 1'b0;
        f0 = frames;
        send(8'h96);
        repeat (60) @(negedge clk);
        check(hold_empty == 1'b0, "R8 byte kept", int'(hold_empty), 0);
        check(tx_busy == 1'b0, "R8 no frame busy", int'(tx_busy), 0);
        check(txd == 1'b1, "R8 line idle", int'(txd), 1);
        check(frames == f0, "R8 no frame sent", frames, f0);
        tx_en = 1'b1;
        wait_idle();
        check(frames == f0 + 1, "R8 sent after enable", frames, f0 + 1);
        check(q.size() == 0, "R4 all frames seen", q.size(), 0);

        finish_run();
    end

endmodule